// File: doc/BRIEF.md
# Dual-Channel Serial Port Register Front End

This block is the bus-facing register set of a two-channel asynchronous serial controller. A processor reaches it over a byte-wide bus. The top address bit picks the channel, and the lower three bits pick a register inside that channel. For each channel the block holds the character-format registers (word length, parity and stop length), an extended mode byte and the rate-select codes. It decodes command writes into receiver and transmitter enables, flush strobes, status clears and break control. It also assembles the status byte.

The serial shifters, the baud generator and the FIFO storage sit outside this block. Level inputs stand in for them (data available, storage full, transmit space, transmitter idle), and so do single-cycle error event inputs. The block passes configuration and strobes back out to them. The three mode registers share one address. An internal pointer steps through them on each write, and two command codes move that pointer back to a starting register.

Top module: `uart_regfront`

## Requirements
- R1: The bus address bit 3 selects the channel (0 = first, 1 = second) and bits [2:0] the local register: 0 mode, 1 status (read) / rate select (write), 2 command (write only, reads 0), 3 receive holding (read) / transmit holding (write). Local addresses 4 to 7 read 0 and ignore writes. When the read strobe is low, the read data is 0.
- R2: The mode pointer starts at the first format register after reset. A write to local address 0 loads the register under the pointer and then advances the pointer: extended mode → first format → second format. Once the pointer reaches the second format register it stays there. A read of local address 0 returns the register under the pointer and does not move it.
- R3: Command code 0x1 (command bits [7:4]) points the mode pointer at the first format register. Code 0xB points it at the extended mode register.
- R4: First format register bits [1:0] give the character length output (0 = 5 bits … 3 = 8 bits). Bits [4:2] give parity: when bit 4 is 1 there is no parity; otherwise parity is enabled and bit 2 selects odd (1) or even (0). Reset values are 0x13 for the first format register, 0x07 for the second and 0x00 for the extended mode register.
- R5: The two-stop-bit output is 1 exactly when the low nibble of the second format register is 0xF. Any other value selects one stop bit.
- R6: Command bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it. When the enable and disable bits of one direction are both set, the disable bit wins. Both directions are disabled at reset.
- R7: Code 0x2 gives a one-cycle receiver flush strobe and masks the data-ready and full status bits. The mask clears once the data-available input is seen low. Code 0x3 gives a one-cycle transmitter flush strobe.
- R8: Code 0x6 turns the break output on and code 0x7 turns it off.
- R9: The status byte is {break, framing, parity, overrun, tx idle, tx ready, rx full, rx ready} from bit 7 down to bit 0. Tx ready is the transmit-space input ANDed with the transmitter enable.
- R10: The overrun, parity, framing and break flags are set by their event inputs and stay set. Code 0x4 clears overrun, parity and framing; code 0x5 clears break. An event in the same cycle as its clear leaves the flag set.
- R11: A write to the rate-select register drives the receive rate code from data bits [7:4] and the transmit rate code from bits [3:0]. Both are 0 after reset.
- R12: A transmit holding write while the transmitter is enabled latches the byte onto the transmit byte output and pulses the load strobe for one cycle. While the transmitter is disabled the write is discarded: there is no strobe and the byte output keeps its value.
- R13: A read of local address 3 returns the channel's received byte input and raises that channel's pop strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Channel bit and local register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| rx_avail | input | 2 | Per channel: received data waiting |
| rx_full | input | 2 | Per channel: receive storage full |
| tx_space | input | 2 | Per channel: transmit storage can accept a byte |
| tx_idle | input | 2 | Per channel: transmitter fully drained |
| ev_overrun | input | 2 | Per channel: overrun event pulse |
| ev_parity | input | 2 | Per channel: parity error event pulse |
| ev_framing | input | 2 | Per channel: framing error event pulse |
| ev_break | input | 2 | Per channel: received break event pulse |
| rx_byte | input | 16 | Per channel: oldest received byte |
| rx_pop | output | 2 | Per channel: receive holding read strobe |
| rx_flush | output | 2 | Per channel: receiver flush strobe |
| tx_flush | output | 2 | Per channel: transmitter flush strobe |
| tx_load | output | 2 | Per channel: transmit byte load strobe |
| tx_byte | output | 16 | Per channel: last accepted transmit byte |
| rx_on | output | 2 | Per channel: receiver enabled |
| tx_on | output | 2 | Per channel: transmitter enabled |
| brk_on | output | 2 | Per channel: send break |
| char_len | output | 4 | Per channel: character length code |
| par_en | output | 2 | Per channel: parity enabled |
| par_odd | output | 2 | Per channel: odd parity |
| stop_two | output | 2 | Per channel: two stop bits |
| rx_rate | output | 8 | Per channel: receive rate code |
| tx_rate | output | 8 | Per channel: transmit rate code |
| ext_mode | output | 16 | Per channel: extended mode register |

## Verification
The bench goes after the mode pointer at its ends. A design that wrapped past the second format register would overwrite the first one on the third write. A design that advanced on reads would return the wrong register. An error event arriving in the same cycle as its clear command is driven on purpose; a design that let the clear win would lose a real error. Receiver flush is tested while data is still reported available, so a design that did not mask ready and full would keep showing stale data. Transmit holding writes are made with the transmitter disabled, so a design that still loaded would send a discarded byte. A long random stretch mixes both channels, which catches any decode that lets one channel's write reach the other.

// File: rtl/uart_regfront_pkg.sv
// Package: shared constants and types for the serial register front end.
// Assumes one byte-wide bus and a 3-bit local register address per channel.
package uart_regfront_pkg;

    localparam int DATA_W = 8;
    localparam int LOC_W  = 3;

    localparam logic [LOC_W-1:0] LOC_MODE = 3'd0;
    localparam logic [LOC_W-1:0] LOC_STAT = 3'd1;
    localparam logic [LOC_W-1:0] LOC_CMD  = 3'd2;
    localparam logic [LOC_W-1:0] LOC_HOLD = 3'd3;

    localparam logic [DATA_W-1:0] EXT_RST = 8'h00;
    localparam logic [DATA_W-1:0] FMT1_RST = 8'h13;
    localparam logic [DATA_W-1:0] FMT2_RST = 8'h07;

    typedef enum logic [1:0] {
        PTR_EXT  = 2'd0,
        PTR_FMT1 = 2'd1,
        PTR_FMT2 = 2'd2
    } mode_ptr_e;

    typedef enum logic [3:0] {
        OP_NONE     = 4'h0,
        OP_PTR_FMT1 = 4'h1,
        OP_RX_FLUSH = 4'h2,
        OP_TX_FLUSH = 4'h3,
        OP_CLR_ERR  = 4'h4,
        OP_CLR_BRK  = 4'h5,
        OP_BRK_SET  = 4'h6,
        OP_BRK_END  = 4'h7,
        OP_PTR_EXT  = 4'hB
    } cmd_op_e;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
        logic ovr;
    } err_flags_t;

endpackage

// File: rtl/uart_mode_bank.sv
// Module: holds the extended mode byte and the two format registers of one
// channel behind a single address, selected by an auto-advancing pointer.
// Assumes write and pointer-jump requests never arrive in the same cycle
// (they come from different local addresses).
module uart_mode_bank
    import uart_regfront_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mode,
    input  logic [DATA_W-1:0] wdata,
    input  logic              goto_ext,
    input  logic              goto_fmt1,
    output logic [DATA_W-1:0] ext_reg,
    output logic [DATA_W-1:0] fmt1_reg,
    output logic [DATA_W-1:0] fmt2_reg,
    output logic [DATA_W-1:0] sel_value
);

    mode_ptr_e ptr;

    // Pointer: jump on command, advance on each mode write, park at the last register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= PTR_FMT1;
        end else if (goto_ext) begin
            ptr <= PTR_EXT;
        end else if (goto_fmt1) begin
            ptr <= PTR_FMT1;
        end else if (wr_mode) begin
            case (ptr)
                PTR_EXT:  ptr <= PTR_FMT1;
                default:  ptr <= PTR_FMT2;
            endcase
        end
    end

    // Register load: the register under the pointer takes the written byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_reg  <= EXT_RST;
            fmt1_reg <= FMT1_RST;
            fmt2_reg <= FMT2_RST;
        end else if (wr_mode) begin
            case (ptr)
                PTR_EXT:  ext_reg  <= wdata;
                PTR_FMT1: fmt1_reg <= wdata;
                default:  fmt2_reg <= wdata;
            endcase
        end
    end

    // Read view: the register currently under the pointer.
    always_comb begin
        case (ptr)
            PTR_EXT:  sel_value = ext_reg;
            PTR_FMT1: sel_value = fmt1_reg;
            default:  sel_value = fmt2_reg;
        endcase
    end

    // R2: writes at the last register keep landing there
    assert_fmt2_parks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && !goto_ext && !goto_fmt1 && ptr == PTR_FMT2)
        |=> (sel_value == $past(wdata)));

    // R3: the extended-register jump is visible on the next read
    assert_jump_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        goto_ext |=> (sel_value == ext_reg && ptr == PTR_EXT));

endmodule

// File: rtl/uart_cmd_unit.sv
// Module: decodes command writes of one channel into enable levels, break
// control, one-cycle flush strobes and same-cycle clear/jump requests.
// Assumes wr_cmd is already qualified by channel and local address.
module uart_cmd_unit
    import uart_regfront_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic [DATA_W-1:0] wdata,
    output logic              rx_on,
    output logic              tx_on,
    output logic              brk_on,
    output logic              rx_flush,
    output logic              tx_flush,
    output logic              goto_ext,
    output logic              goto_fmt1,
    output logic              clr_err,
    output logic              clr_brk,
    output logic              rx_rst
);

    logic [3:0] op;

    // Decode: command field qualified by the write strobe.
    always_comb begin
        op        = wdata[7:4];
        goto_fmt1 = wr_cmd && (op == OP_PTR_FMT1);
        goto_ext  = wr_cmd && (op == OP_PTR_EXT);
        rx_rst    = wr_cmd && (op == OP_RX_FLUSH);
        clr_err   = wr_cmd && (op == OP_CLR_ERR);
        clr_brk   = wr_cmd && (op == OP_CLR_BRK);
    end

    // Enables: disable bit outranks enable bit in each direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_on <= 1'b0;
            tx_on <= 1'b0;
        end else if (wr_cmd) begin
            if (wdata[1])      rx_on <= 1'b0;
            else if (wdata[0]) rx_on <= 1'b1;
            if (wdata[3])      tx_on <= 1'b0;
            else if (wdata[2]) tx_on <= 1'b1;
        end
    end

    // Break level: set and cleared by its two command codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_on <= 1'b0;
        end else if (wr_cmd && op == OP_BRK_SET) begin
            brk_on <= 1'b1;
        end else if (wr_cmd && op == OP_BRK_END) begin
            brk_on <= 1'b0;
        end
    end

    // Flush strobes: one registered cycle per command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_flush <= 1'b0;
            tx_flush <= 1'b0;
        end else begin
            rx_flush <= rx_rst;
            tx_flush <= wr_cmd && (op == OP_TX_FLUSH);
        end
    end

    // R6: disable outranks enable
    assert_disable_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && wdata[1]) |=> !rx_on);

    // R7: a receiver flush command produces the strobe next cycle
    assert_rx_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && wdata[7:4] == 4'h2) |=> rx_flush);

    // R8: break start command raises the break output
    assert_break_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && wdata[7:4] == 4'h6) |=> brk_on);

endmodule

// File: rtl/uart_status_unit.sv
// Module: keeps sticky receive error flags and the post-flush mask of one
// channel, and assembles its status byte.
// Assumes event inputs are single-cycle pulses from the receive shifter.
module uart_status_unit
    import uart_regfront_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_avail,
    input  logic              rx_full,
    input  logic              tx_space,
    input  logic              tx_idle,
    input  logic              ev_overrun,
    input  logic              ev_parity,
    input  logic              ev_framing,
    input  logic              ev_break,
    input  logic              clr_err,
    input  logic              clr_brk,
    input  logic              rx_rst,
    input  logic              tx_on,
    output logic [DATA_W-1:0] status
);

    err_flags_t err;
    logic       flushed;

    // Sticky errors: a new event outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= '0;
        end else begin
            err.ovr <= ev_overrun | (err.ovr & ~clr_err);
            err.par <= ev_parity  | (err.par & ~clr_err);
            err.frm <= ev_framing | (err.frm & ~clr_err);
            err.brk <= ev_break   | (err.brk & ~clr_brk);
        end
    end

    // Flush mask: hides stale receive data until storage reports empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flushed <= 1'b0;
        end else if (rx_rst) begin
            flushed <= 1'b1;
        end else if (!rx_avail) begin
            flushed <= 1'b0;
        end
    end

    // Status byte assembly.
    always_comb begin
        status = {err.brk, err.frm, err.par, err.ovr,
                  tx_idle, tx_space & tx_on,
                  rx_full & ~flushed, rx_avail & ~flushed};
    end

    // R10: an error flag holds until its clear
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && !clr_err) |=> status[5]);

    // R10: event beats simultaneous clear
    assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_overrun |=> status[4]);

    // R7: ready and full drop after a receiver flush
    assert_flush_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst |=> (status[1:0] == 2'b00));

endmodule

// File: rtl/uart_chan_slice.sv
// Module: one complete channel: local address decode, rate select,
// transmit holding, read mux, and the mode, command and status units.
// Assumes sel is high when the bus address targets this channel.
module uart_chan_slice
    import uart_regfront_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [LOC_W-1:0]  loc,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              rx_avail,
    input  logic              rx_full,
    input  logic              tx_space,
    input  logic              tx_idle,
    input  logic              ev_overrun,
    input  logic              ev_parity,
    input  logic              ev_framing,
    input  logic              ev_break,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              rx_pop,
    output logic              rx_flush,
    output logic              tx_flush,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_byte,
    output logic              rx_on,
    output logic              tx_on,
    output logic              brk_on,
    output logic [1:0]        char_len,
    output logic              par_en,
    output logic              par_odd,
    output logic              stop_two,
    output logic [3:0]        rx_rate,
    output logic [3:0]        tx_rate,
    output logic [DATA_W-1:0] ext_mode
);

    logic              wr_mode, wr_rate, wr_cmd, wr_hold;
    logic              goto_ext, goto_fmt1, clr_err, clr_brk, rx_rst;
    logic [DATA_W-1:0] fmt1_reg, fmt2_reg, sel_value, status;

    // Write decode by local address.
    always_comb begin
        wr_mode = wr && sel && (loc == LOC_MODE);
        wr_rate = wr && sel && (loc == LOC_STAT);
        wr_cmd  = wr && sel && (loc == LOC_CMD);
        wr_hold = wr && sel && (loc == LOC_HOLD);
    end

    uart_mode_bank u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mode   (wr_mode),
        .wdata     (wdata),
        .goto_ext  (goto_ext),
        .goto_fmt1 (goto_fmt1),
        .ext_reg   (ext_mode),
        .fmt1_reg  (fmt1_reg),
        .fmt2_reg  (fmt2_reg),
        .sel_value (sel_value)
    );

    uart_cmd_unit u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cmd    (wr_cmd),
        .wdata     (wdata),
        .rx_on     (rx_on),
        .tx_on     (tx_on),
        .brk_on    (brk_on),
        .rx_flush  (rx_flush),
        .tx_flush  (tx_flush),
        .goto_ext  (goto_ext),
        .goto_fmt1 (goto_fmt1),
        .clr_err   (clr_err),
        .clr_brk   (clr_brk),
        .rx_rst    (rx_rst)
    );

    uart_status_unit u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_avail   (rx_avail),
        .rx_full    (rx_full),
        .tx_space   (tx_space),
        .tx_idle    (tx_idle),
        .ev_overrun (ev_overrun),
        .ev_parity  (ev_parity),
        .ev_framing (ev_framing),
        .ev_break   (ev_break),
        .clr_err    (clr_err),
        .clr_brk    (clr_brk),
        .rx_rst     (rx_rst),
        .tx_on      (tx_on),
        .status     (status)
    );

    // Rate select: receive code high nibble, transmit code low nibble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_rate <= '0;
            tx_rate <= '0;
        end else if (wr_rate) begin
            rx_rate <= wdata[7:4];
            tx_rate <= wdata[3:0];
        end
    end

    // Transmit holding: accept only while the transmitter is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_load <= 1'b0;
            tx_byte <= '0;
        end else begin
            tx_load <= wr_hold && tx_on;
            if (wr_hold && tx_on) begin
                tx_byte <= wdata;
            end
        end
    end

    // Format decode for the serial shifter.
    always_comb begin
        char_len = fmt1_reg[1:0];
        par_en   = ~fmt1_reg[4];
        par_odd  = fmt1_reg[2];
        stop_two = (fmt2_reg[3:0] == 4'hF);
    end

    // Read mux and receive pop strobe.
    always_comb begin
        rdata  = '0;
        rx_pop = 1'b0;
        if (rd && sel) begin
            case (loc)
                LOC_MODE: rdata = sel_value;
                LOC_STAT: rdata = status;
                LOC_HOLD: begin
                    rdata  = rx_byte;
                    rx_pop = 1'b1;
                end
                default:  rdata = '0;
            endcase
        end
    end

    // R12: a holding write with the transmitter off never loads
    assert_hold_discard_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hold && !tx_on) |=> (!tx_load && $stable(tx_byte)));

    // R11: rate codes follow the written byte
    assert_rate_split_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rate |=> ({rx_rate, tx_rate} == $past(wdata)));

endmodule

// File: rtl/uart_regfront.sv
// Module: top of the register front end; splits the bus address into a
// channel select and local address and instantiates one slice per channel.
// Assumes NUM_CH is a power of two of at least 2.
module uart_regfront
    import uart_regfront_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int AW    = LOC_W + CH_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          bus_addr,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [7:0]             bus_wdata,
    output logic [7:0]             bus_rdata,
    input  logic [NUM_CH-1:0]      rx_avail,
    input  logic [NUM_CH-1:0]      rx_full,
    input  logic [NUM_CH-1:0]      tx_space,
    input  logic [NUM_CH-1:0]      tx_idle,
    input  logic [NUM_CH-1:0]      ev_overrun,
    input  logic [NUM_CH-1:0]      ev_parity,
    input  logic [NUM_CH-1:0]      ev_framing,
    input  logic [NUM_CH-1:0]      ev_break,
    input  logic [8*NUM_CH-1:0]    rx_byte,
    output logic [NUM_CH-1:0]      rx_pop,
    output logic [NUM_CH-1:0]      rx_flush,
    output logic [NUM_CH-1:0]      tx_flush,
    output logic [NUM_CH-1:0]      tx_load,
    output logic [8*NUM_CH-1:0]    tx_byte,
    output logic [NUM_CH-1:0]      rx_on,
    output logic [NUM_CH-1:0]      tx_on,
    output logic [NUM_CH-1:0]      brk_on,
    output logic [2*NUM_CH-1:0]    char_len,
    output logic [NUM_CH-1:0]      par_en,
    output logic [NUM_CH-1:0]      par_odd,
    output logic [NUM_CH-1:0]      stop_two,
    output logic [4*NUM_CH-1:0]    rx_rate,
    output logic [4*NUM_CH-1:0]    tx_rate,
    output logic [8*NUM_CH-1:0]    ext_mode
);

    logic [DATA_W-1:0] ch_rdata [NUM_CH];
    logic [NUM_CH-1:0] ch_sel;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_sel[c] = (bus_addr[AW-1:LOC_W] == CH_W'(c));

        uart_chan_slice u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel        (ch_sel[c]),
            .loc        (bus_addr[LOC_W-1:0]),
            .wr         (bus_wr),
            .rd         (bus_rd),
            .wdata      (bus_wdata),
            .rdata      (ch_rdata[c]),
            .rx_avail   (rx_avail[c]),
            .rx_full    (rx_full[c]),
            .tx_space   (tx_space[c]),
            .tx_idle    (tx_idle[c]),
            .ev_overrun (ev_overrun[c]),
            .ev_parity  (ev_parity[c]),
            .ev_framing (ev_framing[c]),
            .ev_break   (ev_break[c]),
            .rx_byte    (rx_byte[8*c +: 8]),
            .rx_pop     (rx_pop[c]),
            .rx_flush   (rx_flush[c]),
            .tx_flush   (tx_flush[c]),
            .tx_load    (tx_load[c]),
            .tx_byte    (tx_byte[8*c +: 8]),
            .rx_on      (rx_on[c]),
            .tx_on      (tx_on[c]),
            .brk_on     (brk_on[c]),
            .char_len   (char_len[2*c +: 2]),
            .par_en     (par_en[c]),
            .par_odd    (par_odd[c]),
            .stop_two   (stop_two[c]),
            .rx_rate    (rx_rate[4*c +: 4]),
            .tx_rate    (tx_rate[4*c +: 4]),
            .ext_mode   (ext_mode[8*c +: 8])
        );
    end

    // Read merge: only the selected slice drives a nonzero byte.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            bus_rdata = bus_rdata | ch_rdata[i];
        end
    end

    // R1: at most one channel is selected and pops per read
    assert_one_pop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_pop));

    // R1: no read strobe means a zero read bus
    assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 8'h00));

endmodule

// File: tb/tb_uart_regfront.sv
module tb_uart_regfront;

    localparam int CLK_P    = 10;
    localparam int WATCHDOG = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  rx_avail = '0, rx_full = '0, tx_space = 2'b11, tx_idle = 2'b11;
    logic [1:0]  ev_overrun = '0, ev_parity = '0, ev_framing = '0, ev_break = '0;
    logic [15:0] rx_byte = '0;
    logic [1:0]  rx_pop, rx_flush, tx_flush, tx_load, rx_on, tx_on, brk_on;
    logic [1:0]  par_en, par_odd, stop_two;
    logic [15:0] tx_byte, ext_mode;
    logic [3:0]  char_len;
    logic [7:0]  rx_rate, tx_rate;

    int tests = 0;
    int fails = 0;
    bit checking = 0;

    uart_regfront dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_avail(rx_avail), .rx_full(rx_full), .tx_space(tx_space),
        .tx_idle(tx_idle), .ev_overrun(ev_overrun), .ev_parity(ev_parity),
        .ev_framing(ev_framing), .ev_break(ev_break), .rx_byte(rx_byte),
        .rx_pop(rx_pop), .rx_flush(rx_flush), .tx_flush(tx_flush),
        .tx_load(tx_load), .tx_byte(tx_byte), .rx_on(rx_on), .tx_on(tx_on),
        .brk_on(brk_on), .char_len(char_len), .par_en(par_en),
        .par_odd(par_odd), .stop_two(stop_two), .rx_rate(rx_rate),
        .tx_rate(tx_rate), .ext_mode(ext_mode)
    );

    always #(CLK_P/2) clk = ~clk;

    // Reference model state, per channel. Error index: 0 ovr,1 par,2 frm,3 brk.
    int       m_ptr [2];
    bit [7:0] m_reg [2][3];
    bit [7:0] m_rate [2];
    bit       m_rxon [2], m_txon [2], m_brk [2], m_mask [2];
    bit       m_rxfl [2], m_txfl [2], m_load [2];
    bit [7:0] m_txb [2];
    bit       m_err [2][4];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] m_status(input int ch);
        return {m_err[ch][3], m_err[ch][2], m_err[ch][1], m_err[ch][0],
                tx_idle[ch], tx_space[ch] & m_txon[ch],
                rx_full[ch] & ~m_mask[ch], rx_avail[ch] & ~m_mask[ch]};
    endfunction

    // Model update at each rising edge.
    always @(posedge clk) begin
        for (int ch = 0; ch < 2; ch++) begin
            bit hit, is_cmd, c_err, c_brk, r_rst;
            int loc, op;
            if (!rst_n) begin
                m_ptr[ch] = 1; m_reg[ch][0] = 8'h00; m_reg[ch][1] = 8'h13;
                m_reg[ch][2] = 8'h07; m_rate[ch] = 0; m_rxon[ch] = 0; m_txon[ch] = 0;
                m_brk[ch] = 0; m_mask[ch] = 0; m_rxfl[ch] = 0; m_txfl[ch] = 0;
                m_load[ch] = 0; m_txb[ch] = 0;
                for (int e = 0; e < 4; e++) m_err[ch][e] = 0;
            end else begin
                hit    = bus_wr && (int'(bus_addr[3]) == ch);
                loc    = int'(bus_addr[2:0]);
                op     = int'(bus_wdata[7:4]);
                is_cmd = hit && loc == 2;
                c_err  = is_cmd && op == 4;
                c_brk  = is_cmd && op == 5;
                r_rst  = is_cmd && op == 2;
                m_err[ch][0] = ev_overrun[ch] || (m_err[ch][0] && !c_err);
                m_err[ch][1] = ev_parity[ch]  || (m_err[ch][1] && !c_err);
                m_err[ch][2] = ev_framing[ch] || (m_err[ch][2] && !c_err);
                m_err[ch][3] = ev_break[ch]   || (m_err[ch][3] && !c_brk);
                if (r_rst) m_mask[ch] = 1;
                else if (!rx_avail[ch]) m_mask[ch] = 0;
                m_rxfl[ch] = r_rst;
                m_txfl[ch] = is_cmd && op == 3;
                m_load[ch] = 0;
                if (hit) begin
                    case (loc)
                        0: begin
                            m_reg[ch][m_ptr[ch]] = bus_wdata;
                            m_ptr[ch] = (m_ptr[ch] == 0) ? 1 : 2;
                        end
                        1: m_rate[ch] = bus_wdata;
                        2: begin
                            if (bus_wdata[1]) m_rxon[ch] = 0; else if (bus_wdata[0]) m_rxon[ch] = 1;
                            if (bus_wdata[3]) m_txon[ch] = 0; else if (bus_wdata[2]) m_txon[ch] = 1;
                            if (op == 1) m_ptr[ch] = 1;
                            if (op == 11) m_ptr[ch] = 0;
                            if (op == 6) m_brk[ch] = 1;
                            if (op == 7) m_brk[ch] = 0;
                        end
                        3: if (m_txon[ch]) begin
                            m_load[ch] = 1;
                            m_txb[ch] = bus_wdata;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // Compare every output against the model at each falling edge.
    always @(negedge clk) begin
        if (checking) begin
            int ch, loc;
            bit [7:0] er;
            ch  = int'(bus_addr[3]);
            loc = int'(bus_addr[2:0]);
            er  = 8'h00;
            if (bus_rd) begin
                case (loc)
                    0: er = m_reg[ch][m_ptr[ch]];
                    1: er = m_status(ch);
                    3: er = rx_byte[8*ch +: 8];
                    default: er = 8'h00;
                endcase
            end
            case (loc)
                0: chk("R2", "mode read", int'(bus_rdata), int'(er));
                1: chk("R9", "status read", int'(bus_rdata), int'(er));
                3: chk("R13", "rx holding read", int'(bus_rdata), int'(er));
                default: chk("R1", "unused read", int'(bus_rdata), int'(er));
            endcase
            for (int c = 0; c < 2; c++) begin
                chk("R13", "rx_pop", int'(rx_pop[c]), int'(bus_rd && ch == c && loc == 3));
                chk("R4", "char_len", int'(char_len[2*c +: 2]), int'(m_reg[c][1][1:0]));
                chk("R4", "par_en", int'(par_en[c]), int'(!m_reg[c][1][4]));
                chk("R4", "par_odd", int'(par_odd[c]), int'(m_reg[c][1][2]));
                chk("R5", "stop_two", int'(stop_two[c]), int'(m_reg[c][2][3:0] == 4'hF));
                chk("R2", "ext_mode", int'(ext_mode[8*c +: 8]), int'(m_reg[c][0]));
                chk("R6", "rx_on", int'(rx_on[c]), int'(m_rxon[c]));
                chk("R6", "tx_on", int'(tx_on[c]), int'(m_txon[c]));
                chk("R7", "rx_flush", int'(rx_flush[c]), int'(m_rxfl[c]));
                chk("R7", "tx_flush", int'(tx_flush[c]), int'(m_txfl[c]));
                chk("R8", "brk_on", int'(brk_on[c]), int'(m_brk[c]));
                chk("R11", "rates", int'({rx_rate[4*c +: 4], tx_rate[4*c +: 4]}), int'(m_rate[c]));
                chk("R12", "tx_load", int'(tx_load[c]), int'(m_load[c]));
                chk("R12", "tx_byte", int'(tx_byte[8*c +: 8]), int'(m_txb[c]));
            end
        end
    end

    task automatic cyc(input bit w, input bit r, input logic [3:0] a, input logic [7:0] d);
        @(posedge clk);
        #1;
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        ev_overrun = '0; ev_parity = '0; ev_framing = '0; ev_break = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cyc(1'b1, 1'b0, a, d);
    endtask

    task automatic rd_expect(input logic [3:0] a, input logic [7:0] exp, input string tag);
        cyc(1'b0, 1'b1, a, 8'h00);
        #(CLK_P/2);
        chk(tag, "directed read", int'(bus_rdata), int'(exp));
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        checking = 1;
        #1 rst_n = 1'b1;
        // Reset values (R4, R9, R1)
        rd_expect(4'h0, 8'h13, "R4");
        rd_expect(4'h1, 8'h08, "R9");
        rd_expect(4'h2, 8'h00, "R1");
        // Pointer walk and parking (R2)
        wr(4'h0, 8'h1A);
        rd_expect(4'h0, 8'h07, "R2");
        wr(4'h0, 8'h0F);
        wr(4'h0, 8'h3C);
        rd_expect(4'h0, 8'h3C, "R2");
        // Pointer jumps (R3)
        wr(4'h2, 8'hB0);
        rd_expect(4'h0, 8'h00, "R3");
        wr(4'h0, 8'h81);
        rd_expect(4'h0, 8'h1A, "R3");
        wr(4'h2, 8'h10);
        wr(4'h0, 8'h04);
        rd_expect(4'h0, 8'h3C, "R3");
        // Channel isolation (R1)
        wr(4'h8, 8'h07);
        rd_expect(4'h0, 8'h3C, "R1");
        rd_expect(4'h8, 8'h07, "R1");
        rd_expect(4'h9, 8'h08, "R1");
        rd_expect(4'h5, 8'h00, "R1");
        // Enables, disable priority (R6, R9)
        wr(4'h2, 8'h05);
        rd_expect(4'h1, 8'h0C, "R9");
        wr(4'h2, 8'h03);
        // Transmit holding (R12)
        wr(4'h3, 8'hA5);
        wr(4'h2, 8'h08);
        wr(4'h3, 8'h5A);
        cyc(1'b0, 1'b0, 4'h0, 8'h00);
        // Break and flush codes (R8, R7)
        wr(4'h2, 8'h60);
        wr(4'h2, 8'h70);
        wr(4'h2, 8'h30);
        // Sticky errors (R10)
        cyc(1'b0, 1'b0, 4'h0, 8'h00);
        ev_parity[0] = 1'b1; ev_break[0] = 1'b1;
        rd_expect(4'h1, 8'hA8, "R10");
        wr(4'h2, 8'h40);
        rd_expect(4'h1, 8'h88, "R10");
        wr(4'h2, 8'h50);
        rd_expect(4'h1, 8'h08, "R10");
        wr(4'h2, 8'h40);
        ev_overrun[0] = 1'b1;
        rd_expect(4'h1, 8'h18, "R10");
        wr(4'h2, 8'h40);
        rd_expect(4'h1, 8'h08, "R10");
        // Receiver flush masking (R7)
        rx_avail[0] = 1'b1; rx_full[0] = 1'b1;
        rd_expect(4'h1, 8'h0B, "R7");
        wr(4'h2, 8'h20);
        rd_expect(4'h1, 8'h08, "R7");
        rx_avail[0] = 1'b0;
        cyc(1'b0, 1'b0, 4'h0, 8'h00);
        rx_avail[0] = 1'b1;
        rd_expect(4'h1, 8'h0B, "R7");
        // Receive holding read (R13) and rate select (R11)
        rx_byte = 16'h773E;
        rd_expect(4'h3, 8'h3E, "R13");
        rd_expect(4'hB, 8'h77, "R13");
        wr(4'h1, 8'h9C);
        wr(4'h9, 8'h21);
        // Random mixed traffic on both channels
        for (int i = 0; i < 4000; i++) begin
            int k;
            k = int'($urandom % 6);
            cyc(k < 2, k == 2 || k == 3, 4'($urandom), 8'($urandom));
            if ($urandom % 8 == 0) ev_overrun = 2'($urandom);
            if ($urandom % 8 == 0) ev_parity  = 2'($urandom);
            if ($urandom % 8 == 0) ev_framing = 2'($urandom);
            if ($urandom % 8 == 0) ev_break   = 2'($urandom);
            if ($urandom % 4 == 0) rx_avail   = 2'($urandom);
            if ($urandom % 4 == 0) rx_full    = 2'($urandom);
            if ($urandom % 4 == 0) tx_space   = 2'($urandom);
            if ($urandom % 4 == 0) tx_idle    = 2'($urandom);
            rx_byte = 16'($urandom);
        end
        cyc(1'b0, 1'b0, 4'h0, 8'h00);
        @(posedge clk);
        #(CLK_P/2 + 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule